// File: doc/BRIEF.md
# Resonant Push-Pull Drive Controller

This block turns an enable request into a self-oscillating two-phase gate drive for a resonant load. The load's current polarity comes back as a single digitised feedback bit. While the block is running, that bit sets the drive directly: phase A follows it and phase B follows its inverse. This positive feedback keeps the load swinging at its own natural frequency without any frequency setting inside the block. When the enable goes high, phase B is driven first, because the feedback is low at rest. That first pulse kicks the load.

Shutdown waits for the current to reach zero. After the enable is removed, the run state persists until the synchronised feedback shows a falling edge. The run state then clears and both phases drop together. If no such edge comes, a timeout forces the block idle. The timeout is measured from the moment the enable falls, and raising the enable again cancels it.

The feedback bit is asynchronous to the system clock and passes through a synchroniser before use. All outputs are registered.

Top module: `resonant_drive`

## Requirements
- R1: While reset is asserted (rstN low), and at the first sample after it, running, phaseA and phaseB are all 0.
- R2: At every clock edge that samples enable high, running becomes 1. While enable stays high, running stays 1.
- R3: While the block is running, phaseA after clock edge k equals the value of fbRaw sampled at edge k-2. This two-cycle latency comes from the synchroniser.
- R4: While the block is running, phaseB is the inverse of phaseA. The first enable edge with the feedback low therefore drives phaseB to 1.
- R5: After enable goes low, running stays 1 until a falling edge of the synchronised feedback is seen. If fbRaw was sampled 1 at edge m-1 and 0 at edge m, running clears at edge m+2.
- R6: If no falling feedback edge arrives, running clears at exactly the TIMEOUT-th clock edge after the first edge that samples enable low.
- R7: Any edge that samples enable high cancels a timeout in progress. The timeout restarts from its full length at the next fall of enable.
- R8: phaseA and phaseB are never 1 in the same cycle.
- R9: While the block is idle, feedback activity has no effect: running, phaseA and phaseB all stay 0.
- R10: Both phases are 0 from the same clock edge at which running clears, whether running clears on a feedback edge or on the timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Drive request |
| fbRaw | input | 1 | Asynchronous current-polarity feedback |
| phaseA | output | 1 | Gate drive, in phase with the feedback |
| phaseB | output | 1 | Gate drive, inverse of the feedback |
| running | output | 1 | Run state is set |

## Verification
The bench builds the block with TIMEOUT set to 16 and keeps the two-stage synchroniser. With this setting, the exact timeout edge and a timeout cancelled part-way can both be measured within a few dozen cycles. The random phase of the bench holds the feedback still for stretches of 20 to 40 cycles, which is longer than the timeout. As a result, shutdown by timeout and shutdown at a zero crossing both occur many times, mixed with enable pulses that arrive during the countdown.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic driveOn;   // run state as it will be after this edge
  } rdc_strobe_t;
endpackage

// File: rtl/rdc_datapath.sv
module rdc_datapath
  import rdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fbRaw,
  input  rdc_strobe_t strobe,
  output logic        fbFall,
  output logic        phaseA,
  output logic        phaseB
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic fbLvl, fbPrev;
  logic aNext, bNext;

  assign fbLvl  = syncQ[SYNC_STAGES-1];
  assign fbFall = fbPrev & ~fbLvl;

  // phase B is suppressed whenever phase A is about to be high
  assign aNext = strobe.driveOn & fbLvl;
  assign bNext = strobe.driveOn & ~fbLvl & ~aNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ  <= '0;
      fbPrev <= 1'b0;
      phaseA <= 1'b0;
      phaseB <= 1'b0;
    end else begin
      syncQ  <= {syncQ[SYNC_STAGES-2:0], fbRaw};
      fbPrev <= fbLvl;
      phaseA <= aNext;
      phaseB <= bNext;
    end
  end
endmodule

// File: rtl/rdc_control.sv
module rdc_control
  import rdc_pkg::*;
#(
  parameter int TIMEOUT = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        fbFall,
  output rdc_strobe_t strobe,
  output logic        running
);
  localparam int CW = $clog2(TIMEOUT) + 1;

  logic          runQ, enPrev, armed, expire, runNext;
  logic [CW-1:0] cnt;

  assign expire  = armed & ~enable & (cnt == '0);
  // enable acts as an overriding set; clear at a zero crossing or on expiry
  assign runNext = enable | (runQ & ~fbFall & ~expire);

  assign strobe.driveOn = runNext;
  assign running        = runQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      enPrev <= 1'b0;
      armed  <= 1'b0;
      cnt    <= '0;
    end else begin
      runQ   <= runNext;
      enPrev <= enable;
      if (enable) begin
        armed <= 1'b0;
      end else if (enPrev) begin
        armed <= runNext;
        cnt   <= CW'(TIMEOUT - 1);
      end else if (armed) begin
        if (!runNext) armed <= 1'b0;
        else          cnt   <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/resonant_drive.sv
module resonant_drive
  import rdc_pkg::*;
#(
  parameter int TIMEOUT     = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic fbRaw,
  output logic phaseA,
  output logic phaseB,
  output logic running
);
  rdc_strobe_t strobe;
  logic        fbFall;

  rdc_control #(.TIMEOUT(TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .fbFall(fbFall),
    .strobe(strobe), .running(running)
  );

  rdc_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .fbRaw(fbRaw), .strobe(strobe),
    .fbFall(fbFall), .phaseA(phaseA), .phaseB(phaseB)
  );
endmodule

// File: rtl/rdc_checker.sv
module rdc_checker #(
  parameter int TIMEOUT = 1024
) (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic running,
  input logic phaseA,
  input logic phaseB
);
  localparam int WW = $clog2(TIMEOUT + 2) + 1;
  logic [WW-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN || enable || !running) waitCnt <= '0;
    else                             waitCnt <= waitCnt + 1'b1;
  end

  // R8
  phases_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(phaseA && phaseB));
  // R2
  enable_runs_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> running);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (!phaseA && !phaseB));
  // R6
  timeout_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (waitCnt <= WW'(TIMEOUT)));
  // R5
  stop_needs_low_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> !$past(enable));
endmodule

bind resonant_drive rdc_checker #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .running(running),
  .phaseA(phaseA), .phaseB(phaseB)
);

// File: tb/resonant_drive_tb.sv
`timescale 1ns/1ps
module resonant_drive_tb;
  localparam int TO = 16;

  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0, fbRaw = 1'b0;
  logic phaseA, phaseB, running;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  resonant_drive #(.TIMEOUT(TO)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .fbRaw(fbRaw),
    .phaseA(phaseA), .phaseB(phaseB), .running(running)
  );

  // reference model built from the requirements
  logic [2:0] mHist;
  logic mRun, mA, mB;
  int   mLow;

  function automatic logic nextRun(logic en, logic run, logic [2:0] h, int low);
    logic fall = h[2] & ~h[1];
    if (en) return 1'b1;
    return run && !fall && (low != TO);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mHist <= '0; mRun <= 1'b0; mA <= 1'b0; mB <= 1'b0; mLow <= 0;
    end else begin
      automatic logic nr = nextRun(enable, mRun, mHist, mLow);
      mRun  <= nr;
      mA    <= nr & mHist[1];
      mB    <= nr & ~mHist[1];
      mLow  <= (enable || !mRun) ? 0 : mLow + 1;
      mHist <= {mHist[1:0], fbRaw};
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkInt(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmpModel();
    chk("R2 running vs model", running, mRun);
    chk("R3 phaseA vs model", phaseA, mA);
    chk("R4 phaseB vs model", phaseB, mB);
    chk("R8 phases exclusive", phaseA & phaseB, 1'b0);
  endtask

  // drive inputs at a negedge, wait one cycle, compare at the next negedge
  task automatic step(logic e, logic f);
    enable = e; fbRaw = f;
    @(negedge clk);
    cmpModel();
  endtask

  // counts edges after enable drops until running clears
  task automatic measureStop(output int n);
    n = 0;
    for (int i = 0; i < TO + 6; i++) begin
      step(1'b0, 1'b0);
      n++;
      if (!running) break;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    int n;
    int half, phaseCnt, stall;
    logic fbGen;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1 reset running", running, 1'b0);
    chk("R1 reset phaseA", phaseA, 1'b0);
    chk("R1 reset phaseB", phaseB, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", running | phaseA | phaseB, 1'b0);

    // R9: idle feedback toggling has no effect
    for (int i = 0; i < 12; i++) begin
      step(1'b0, i[1]);
      chk("R9 idle quiet", running | phaseA | phaseB, 1'b0);
    end
    repeat (4) step(1'b0, 1'b0);

    // R2 / R4: start, feedback low -> phaseB first
    step(1'b1, 1'b0);
    chk("R2 running on enable", running, 1'b1);
    chk("R4 first kick phaseB", phaseB, 1'b1);
    chk("R4 first kick phaseA", phaseA, 1'b0);
    // R3: two-cycle latency
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    chk("R3 phaseA before latency", phaseA, 1'b0);
    step(1'b1, 1'b1);
    chk("R3 phaseA follows fb", phaseA, 1'b1);
    chk("R4 phaseB inverse", phaseB, 1'b0);

    // R5: deferred shutdown at falling feedback
    repeat (4) step(1'b0, 1'b1);
    chk("R5 held after enable low", running, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R5 still running before edge", running, 1'b1);
    step(1'b0, 1'b0);
    chk("R5 cleared at crossing", running, 1'b0);
    chk("R10 phases low with stop", phaseA | phaseB, 1'b0);

    // R6: timeout with no crossing (first edge after drop counts as n=1)
    step(1'b1, 1'b0); step(1'b1, 1'b0);
    measureStop(n);
    chkInt("R6 timeout edge", n, TO + 1);
    chk("R10 phases low after timeout", phaseA | phaseB, 1'b0);

    // R7: re-arm during countdown
    step(1'b1, 1'b0); step(1'b1, 1'b0);
    repeat (TO - 3) step(1'b0, 1'b0);
    chk("R7 running mid countdown", running, 1'b1);
    step(1'b1, 1'b0);
    measureStop(n);
    chkInt("R7 restart full timeout", n, TO + 1);

    // random phase: oscillating feedback with stalls
    fbGen = 1'b0; half = 3; phaseCnt = 0; stall = 0;
    for (int i = 0; i < 4000; i++) begin
      logic en;
      en = enable;
      if ($urandom_range(0, 99) < 4) en = ~en;
      if (stall > 0) stall--;
      else begin
        phaseCnt++;
        if (phaseCnt >= half) begin
          phaseCnt = 0;
          fbGen = ~fbGen;
          half = $urandom_range(2, 7);
          if ($urandom_range(0, 99) < 8) stall = $urandom_range(20, 40);
        end
      end
      step(en, fbGen);
    end

    step(1'b0, 1'b0);
    finishRun();
  end
endmodule